// File: doc/BRIEF.md
# Fractional-Divider PWM Timebase

This block is the shared time reference for a bank of PWM channels. A source enable, taken either from every cycle of the system clock or from a slow reference tick pulse, feeds a phase-accumulator divider. The divider ratio is an unsigned fixed-point number with eight fraction bits, so the tick rate can be any ratio of the source rate from 1 down to about 1/1024. Each divided tick advances a counter that wraps after 2^N counts. The count value and a one-cycle wrap strobe go to the comparators of the PWM channels.

Divider and resolution values are written to plain inputs and captured by an update strobe. The captured values wait in a staging register. They reach the running timebase only at the next counter wrap, or at once while the counter is held clear. A running period is therefore never cut short or stretched by a new setting. Pause freezes the whole timebase. Clear zeroes the count and restarts the divider phase. The block has no data stream, so there is no valid/ready handshake. Every pin is a plain level or pulse control sampled on each clock edge.

Top module: `pwm_timebase`

## Requirements
- R1: While `rst_n` is low, `cnt_o` and `ovf_o` are 0. The reset configuration is divider RST_DIV (default 256) and resolution RST_RES (default 3). With the fast source selected and clear low, the first `ovf_o` therefore appears after the 2^RST_RES*RST_DIV/256 + 1 th rising edge following reset release.
- R2: The divider `cfg_div_i` is unsigned 10.8 fixed point, with bits [7:0] as the fraction. From a fresh start, the k-th divided tick is produced on the ceil(k*div/256)-th enabled source cycle. The average period is therefore exactly 2^N*div/256 source cycles.
- R3: A divider value below 256, including 0, acts exactly like 256: one tick per enabled source cycle.
- R4: The counter counts 0 .. 2^N-1, where N is `cfg_res_i`. A value of N above CW is treated as CW. `cnt_o` never exceeds 2^N-1.
- R5: `ovf_o` is high for one cycle per wrap: in the cycle after the tick that moved the counter from 2^N-1 to 0. Whenever `ovf_o` is high, `cnt_o` is 0. A fresh start reaches its k-th strobe at rising edge ceil(k*2^N*div/256)+1.
- R6: `src_fast_i`=1 enables the divider on every clock cycle and ignores `ref_tick_i`. `src_fast_i`=0 enables it only in cycles where `ref_tick_i` is 1. With a reference pulse every R cycles, all strobe times scale by R.
- R7: While `clear_i` is high, `cnt_o` is 0 and `ovf_o` is 0 after the next edge, and the divider phase is zeroed. Counting restarts fresh on the first edge with clear low.
- R8: While `pause_i` is high (and clear low), `cnt_o` holds its value, `ovf_o` stays 0 and no divider phase is lost. A pause of P cycles delays every later strobe by exactly P cycles.
- R9: `cfg_div_i` and `cfg_res_i` have no effect unless `update_i` is high. Values captured by `update_i` take effect at the next counter wrap, or on the same edge if `clear_i` is high. Applying them at a wrap restarts the divider phase from zero on that edge.
- R10: On each edge with clear low, `cnt_o` either keeps its value, increases by exactly 1, or returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick_i | input | 1 | Slow reference tick, one-cycle pulses in the clk domain |
| src_fast_i | input | 1 | Source select: 1 = every clk cycle, 0 = reference tick |
| cfg_div_i | input | 18 | Divider, unsigned 10.8 fixed point |
| cfg_res_i | input | 5 | Resolution N; counter range is 2^N |
| pause_i | input | 1 | Freeze counter and divider |
| clear_i | input | 1 | Hold counter at zero and reset divider phase |
| update_i | input | 1 | Capture divider and resolution into staging |
| cnt_o | output | CW | Current count |
| ovf_o | output | 1 | One-cycle wrap strobe |

## Verification
The checker watches four things on every cycle. The count stays within the active range. It only holds, steps by one or returns to zero. A strobe always coincides with a zero count. Clear and pause freeze the outputs as required.

Exact wrap timing can only be shown by the bench scenarios. These cover the fractional spacing of the wrap strobes, the clamping of the divider and resolution, and reference-tick scaling. They also cover the pause time shift and the deferred take-up of staged settings at a wrap. The bench sweeps divider and resolution over a 6-bit counter and predicts every strobe edge from ceiling arithmetic.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;
  localparam int DIV_W  = 18;
  localparam int FRAC_W = 8;
  localparam int RES_W  = 5;
  localparam logic [DIV_W-1:0] DIV_UNITY = DIV_W'(1 << FRAC_W);

  typedef struct packed {
    logic [DIV_W-1:0] div;
    logic [RES_W-1:0] res;
  } tb_cfg_t;
endpackage

// File: rtl/pwmtb_cfg_stage.sv
module pwmtb_cfg_stage
  import pwmtb_pkg::*;
#(
  parameter int CW      = 20,
  parameter int RST_DIV = 256,
  parameter int RST_RES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [RES_W-1:0] res_i,
  input  logic             apply_i,
  output tb_cfg_t          act_o,
  output logic             taken_o
);
  localparam logic [RES_W-1:0] RES_MAX = RES_W'(CW);
  localparam tb_cfg_t RST_CFG = '{div: DIV_W'(RST_DIV), res: RES_W'(RST_RES)};

  tb_cfg_t staged_q, nxt;
  logic    pend_q, have;

  function automatic tb_cfg_t limit(input tb_cfg_t c);
    tb_cfg_t r;
    r.div = (c.div < DIV_UNITY) ? DIV_UNITY : c.div;
    r.res = (c.res > RES_MAX) ? RES_MAX : c.res;
    return r;
  endfunction

  always_comb begin
    nxt     = upd_i ? '{div: div_i, res: res_i} : staged_q;
    have    = upd_i | pend_q;
    taken_o = apply_i & have;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= RST_CFG;
      pend_q   <= 1'b0;
      act_o    <= limit(RST_CFG);
    end else begin
      if (upd_i) staged_q <= nxt;
      if (taken_o) begin
        act_o  <= limit(nxt);
        pend_q <= 1'b0;
      end else if (upd_i) begin
        pend_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwmtb_frac_div.sv
module pwmtb_frac_div
  import pwmtb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             hold_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  localparam int ACC_W = DIV_W + 1;

  logic [DIV_W-1:0] acc_q;
  logic [ACC_W-1:0] sum, rem;
  logic             hit;

  always_comb begin
    sum = {1'b0, acc_q} + ACC_W'(DIV_UNITY);
    hit = sum >= {1'b0, div_i};
    rem = sum - {1'b0, div_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (clr_i) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else if (!hold_i) begin
      if (en_i) begin
        acc_q  <= hit ? rem[DIV_W-1:0] : sum[DIV_W-1:0];
        tick_o <= hit;
      end else begin
        tick_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pwmtb_counter.sv
module pwmtb_counter
  import pwmtb_pkg::*;
#(
  parameter int CW = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             hold_i,
  input  logic             clr_i,
  input  logic [RES_W-1:0] res_i,
  output logic [CW-1:0]    cnt_o,
  output logic             ovf_o,
  output logic             wrap_o,
  output logic [CW-1:0]    max_o
);
  logic [CW:0] one_sh;
  logic        step;

  always_comb begin
    one_sh = (CW+1)'(1) << res_i;
    max_o  = CW'(one_sh - (CW+1)'(1));
    step   = tick_i & ~hold_i;
    wrap_o = step & ~clr_i & (cnt_o == max_o);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else if (clr_i) begin
      cnt_o <= '0;
      ovf_o <= 1'b0;
    end else if (step) begin
      cnt_o <= wrap_o ? '0 : cnt_o + 1'b1;
      ovf_o <= wrap_o;
    end else begin
      ovf_o <= 1'b0;
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwmtb_pkg::*;
#(
  parameter int CW      = 20,
  parameter int RST_DIV = 256,
  parameter int RST_RES = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick_i,
  input  logic             src_fast_i,
  input  logic [DIV_W-1:0] cfg_div_i,
  input  logic [RES_W-1:0] cfg_res_i,
  input  logic             pause_i,
  input  logic             clear_i,
  input  logic             update_i,
  output logic [CW-1:0]    cnt_o,
  output logic             ovf_o
);
  tb_cfg_t       act;
  logic          taken, wrap, tick, src_en;
  logic [CW-1:0] cnt_max;

  assign src_en = src_fast_i | ref_tick_i;

  pwmtb_cfg_stage #(.CW(CW), .RST_DIV(RST_DIV), .RST_RES(RST_RES)) u_stage (
    .clk(clk), .rst_n(rst_n), .upd_i(update_i), .div_i(cfg_div_i),
    .res_i(cfg_res_i), .apply_i(clear_i | wrap), .act_o(act), .taken_o(taken)
  );

  pwmtb_frac_div u_div (
    .clk(clk), .rst_n(rst_n), .en_i(src_en), .hold_i(pause_i),
    .clr_i(clear_i | taken), .div_i(act.div), .tick_o(tick)
  );

  pwmtb_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .hold_i(pause_i), .clr_i(clear_i),
    .res_i(act.res), .cnt_o(cnt_o), .ovf_o(ovf_o), .wrap_o(wrap), .max_o(cnt_max)
  );
endmodule

// File: rtl/pwmtb_checker.sv
module pwmtb_checker #(
  parameter int CW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clear_i,
  input logic          pause_i,
  input logic [CW-1:0] cnt_o,
  input logic          ovf_o,
  input logic [CW-1:0] cnt_max
);
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (cnt_o == '0 && !ovf_o)); // R7
  AST_PAUSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (pause_i && !clear_i) |=> ($stable(cnt_o) && !ovf_o)); // R8
  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> cnt_o == '0); // R5
  AST_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_o <= cnt_max); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_i |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_o) + 1'b1 || cnt_o == '0)); // R10
endmodule

bind pwm_timebase pwmtb_checker #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .pause_i(pause_i),
  .cnt_o(cnt_o), .ovf_o(ovf_o), .cnt_max(cnt_max)
);

// File: tb/pwm_timebase_tb.sv
module pwm_timebase_tb;
  localparam int CW = 6;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic          ref_tick_i = 1'b0, src_fast_i = 1'b1;
  logic [17:0]   cfg_div_i = 18'd0;
  logic [4:0]    cfg_res_i = 5'd0;
  logic          pause_i = 1'b0, clear_i = 1'b0, update_i = 1'b0;
  logic [CW-1:0] cnt_o;
  logic          ovf_o;

  int errs = 0, chks = 0, cyc = 0;

  pwm_timebase #(.CW(CW), .RST_DIV(256), .RST_RES(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .ref_tick_i(ref_tick_i), .src_fast_i(src_fast_i),
    .cfg_div_i(cfg_div_i), .cfg_res_i(cfg_res_i), .pause_i(pause_i),
    .clear_i(clear_i), .update_i(update_i), .cnt_o(cnt_o), .ovf_o(ovf_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errs++; chks++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cyc, 150000);
      $display("  Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    chks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint cdiv(input longint x);
    return (x + 255) / 256;
  endfunction

  task automatic step_edge();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Clear held while the update is applied (R9), then released.
  task automatic start(input int div, input int res, input bit fast);
    clear_i = 1'b1; update_i = 1'b1;
    cfg_div_i = 18'(div); cfg_res_i = 5'(res); src_fast_i = fast; ref_tick_i = 1'b0;
    step_edge();
    update_i = 1'b0;
    step_edge();
    chk(cnt_o == 0 && !ovf_o, "R7 clear", cnt_o, 0);
    clear_i = 1'b0;
  endtask

  task automatic run_cfg(input int div, input int res, input bit fast, input int rr,
                         input int nper, input string tag);
    int       t[4];
    int       got = 0;
    int       neff = (res > CW) ? CW : res;
    longint   deff = (div < 256) ? 256 : div;
    longint   per = (longint'(1) << neff) * deff;
    int       limit = rr * int'(cdiv(per * (nper + 1))) + 10;
    bit       bad_rng = 0, bad_zero = 0, bad_step = 0;
    logic [CW-1:0] prev = '0;
    start(div, res, fast);
    ref_tick_i = fast ? 1'b1 : (1 % rr == 0);
    for (int n = 1; n <= limit && got < nper; n++) begin
      step_edge();
      if (cnt_o > CW'((1 << neff) - 1)) bad_rng = 1;
      if (!(cnt_o == prev || cnt_o == prev + 1'b1 || cnt_o == 0)) bad_step = 1;
      prev = cnt_o;
      if (ovf_o) begin
        if (cnt_o != 0) bad_zero = 1;
        t[got] = n; got++;
      end
      // in fast mode the reference input toggles to show it is ignored (R6)
      ref_tick_i = fast ? (((n + 1) % 3) == 0) : (((n + 1) % rr) == 0);
    end
    chk(got == nper, {tag, " strobe count"}, got, nper);
    for (int k = 0; k < got; k++)
      chk(t[k] == rr * cdiv(per * (k + 1)) + 1, {tag, " strobe edge"}, t[k],
          rr * cdiv(per * (k + 1)) + 1);
    chk(!bad_rng, "R4 range", bad_rng, 0);
    chk(!bad_zero, "R5 zero at strobe", bad_zero, 0);
    chk(!bad_step, "R10 step", bad_step, 0);
    ref_tick_i = 1'b0;
  endtask

  initial begin
    int n;
    int held;
    bit ok;
    int t[3];
    int got;
    bit seen7;
    int ds[8] = '{256, 300, 384, 512, 700, 1000, 100, 0};
    int rs[5] = '{0, 1, 3, 6, 31};

    // R1: reset state and reset configuration
    repeat (3) @(negedge clk);
    chk(cnt_o == 0 && !ovf_o, "R1 in reset", cnt_o, 0);
    rst_n = 1'b1;
    n = 0;
    for (int i = 1; i <= 30 && n == 0; i++) begin
      step_edge();
      if (ovf_o) n = i;
    end
    chk(n == 9, "R1 default first strobe", n, 9);

    // R2/R3/R4 sweep, fast source
    foreach (ds[i]) foreach (rs[j])
      run_cfg(ds[i], rs[j], 1'b1, 1, 3,
              (ds[i] < 256) ? "R3" : ((rs[j] > CW) ? "R4" : "R2"));

    // R6: reference tick source, pulse every 3 cycles
    run_cfg(256, 2, 1'b0, 3, 2, "R6");
    run_cfg(384, 2, 1'b0, 3, 2, "R6");
    run_cfg(700, 5, 1'b0, 3, 2, "R6");

    // R8: pause shifts everything by its length
    start(384, 3, 1'b1);
    n = 0;
    while (cnt_o != 3 && n < 40) begin step_edge(); n++; end
    pause_i = 1'b1; held = cnt_o; ok = 1;
    repeat (7) begin
      step_edge(); n++;
      if (cnt_o != CW'(held) || ovf_o) ok = 0;
    end
    chk(ok, "R8 frozen", cnt_o, held);
    pause_i = 1'b0;
    got = 0;
    while (got == 0 && n < 80) begin step_edge(); n++; if (ovf_o) got = n; end
    chk(got == 20, "R8 delayed strobe", got, 20);

    // R9: staged settings ignored without update, taken at the next wrap
    start(512, 3, 1'b1);
    cfg_div_i = 18'd256; cfg_res_i = 5'd2;
    got = 0; seen7 = 0; n = 0;
    while (got < 3 && n < 80) begin
      step_edge(); n++;
      update_i = (n == 20);
      if (n > 21 && cnt_o == 7) seen7 = 1;
      if (ovf_o) begin
        if (got == 0) chk(n == 17, "R9 inputs ignored", n, 17);
        t[got] = n; got++;
      end
    end
    update_i = 1'b0;
    chk(seen7, "R9 old range kept until wrap", seen7, 1);
    chk(t[0] == 17 && t[1] == 33, "R9 old period", t[1], 33);
    chk(t[2] == 38, "R9 new period after wrap", t[2], 38);

    // R7: clear mid-run
    clear_i = 1'b1; ok = 1;
    repeat (3) begin step_edge(); if (cnt_o != 0 || ovf_o) ok = 0; end
    chk(ok, "R7 clear held", cnt_o, 0);
    clear_i = 1'b0;

    $display("  Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end
endmodule